// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Hourly Trim

This block is the timekeeping core of a real-time clock. It takes a single-cycle enable that pulses at the oscillator rate (32768 per second by default). It divides that rate down to seconds and keeps counters for seconds, minutes and hours. Each rollover of those counters is reported as a one-cycle pulse.

A steady crystal error is cancelled without touching the divider. In the first second of every hour, a signed 16-bit trim count is applied: that one second lasts the nominal count minus the trim, so a positive trim shortens it and a negative trim lengthens it. The resolution is one tick per hour. For example, a trim of 4915 removes roughly 3.6 seconds per day.

Software reaches the block through a small byte-wide register port:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | bit 0 run, bit 1 trim enable |
| 1 | trim low byte | written to a holding byte |
| 2 | trim high byte | commits the full 16-bit trim |

Top module: `rtc_trim_core`

## Requirements
- R1: With the trim enable clear, or in any second other than the first second of an hour, a second lasts exactly TICKS_PER_SEC ticks.
- R2: Control register at address 0 has bit 1 as trim enable. With it set, the second that begins with minutes and seconds both zero lasts TICKS_PER_SEC minus the trim, where the trim is a 16-bit two's complement value with its low byte at address 1 and high byte at address 2. A positive trim shortens that second.
- R3: A negative trim lengthens the trimmed second, up to TICKS_PER_SEC + 32768 ticks for a trim of 0x8000, with no overflow of the tick counter; the tick counter always stays below the current second's length.
- R4: The trim enable and the trim value are sampled when a second begins; a second that began with the enable clear lasts TICKS_PER_SEC ticks.
- R5: A write to address 1 only loads a holding byte; the committed trim, read back at addresses 1 and 2, changes only on a write to address 2, which commits {written byte, holding byte} at once.
- R6: A trim committed part-way through a second does not alter that second's length; it applies from the next second that begins.
- R7: Seconds wrap at SECS_PER_MIN, minutes at MINS_PER_HOUR and hours at HOURS_PER_DAY. Each completed second, minute wrap, hour wrap and day wrap raises its own output pulse for one cycle, in the cycle in which the counters show the new time.
- R8: Bit 0 of the control register is run. While it is clear, the tick counter and the time counters hold their values, and on restart the interrupted second resumes where it stopped.
- R9: After reset, the time is 0:00:00, no pulse is raised, and all registers read zero.
- R10: A trim that would make the trimmed second zero or fewer ticks long gives a second of exactly one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse at the oscillator rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 trim low, 2 trim high) |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| sec_o | output | TW | Seconds count |
| min_o | output | TW | Minutes count |
| hour_o | output | TW | Hours count |
| sec_tick_o | output | 1 | Pulse: a second completed |
| min_tick_o | output | 1 | Pulse: seconds wrapped |
| hour_tick_o | output | 1 | Pulse: minutes wrapped |
| day_tick_o | output | 1 | Pulse: hours wrapped |

## Verification
The bench builds the core with the following parameters:

| Parameter | Bench value |
|-----------|-------------|
| TICKS_PER_SEC | 16 |
| SECS_PER_MIN | 5 |
| MINS_PER_HOUR | 3 |
| HOURS_PER_DAY | 2 |

With these values an hour is 15 seconds and a day 30 seconds. The trimmed first second of each hour, and every rollover up to the day wrap, therefore come around within a few hundred cycles. The trim register keeps its full 16-bit width, so the most negative trim still yields a 32784-tick second. A trim larger than the nominal count exercises the one-tick floor.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
    localparam int COMP_W = 16;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_TRIM_LO = 2'd1,
        REG_TRIM_HI = 2'd2,
        REG_NONE    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic trim_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
    import rtc_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output ctrl_t             ctrl_o,
    output logic [COMP_W-1:0] trim_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [7:0]        hold;
        logic [COMP_W-1:0] trim;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            case (reg_addr_e'(addr_i))
                REG_CTRL:    r_d.ctrl = ctrl_t'(wdata_i[1:0]);
                REG_TRIM_LO: r_d.hold = wdata_i;
                REG_TRIM_HI: r_d.trim = COMP_W'({wdata_i, r_q.hold});
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(addr_i))
            REG_CTRL:    rdata_o = {6'b0, r_q.ctrl};
            REG_TRIM_LO: rdata_o = r_q.trim[7:0];
            REG_TRIM_HI: rdata_o = r_q.trim[15:8];
            default:     rdata_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o = r_q.ctrl;
    assign trim_o = r_q.trim;
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
    import rtc_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int CW            = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              trim_en_i,
    input  logic [COMP_W-1:0] trim_i,
    input  logic              hour_next_i,
    output logic              sec_end_o,
    output logic [CW-1:0]     cnt_o,
    output logic [CW-1:0]     len_o
);
    localparam int SW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
    } pre_t;

    pre_t p_d, p_q;
    logic signed [SW-1:0] trim_s, len_s;
    logic [CW-1:0] trim_len;
    logic adv, last;

    always_comb begin
        trim_s = SW'($signed(trim_i));
        len_s  = SW'(TICKS_PER_SEC) - trim_s;
        if (len_s[SW-1] || (len_s == '0)) trim_len = CW'(1);
        else                              trim_len = len_s[CW-1:0];

        adv       = run_i && tick_i;
        last      = (p_q.cnt == (p_q.len - CW'(1)));
        sec_end_o = adv && last;

        p_d = p_q;
        if (adv) p_d.cnt = last ? '0 : (p_q.cnt + CW'(1));
        if (sec_end_o)
            p_d.len = (trim_en_i && hour_next_i) ? trim_len : CW'(TICKS_PER_SEC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{cnt: '0, len: CW'(TICKS_PER_SEC)};
        else        p_q <= p_d;
    end

    assign cnt_o = p_q.cnt;
    assign len_o = p_q.len;
endmodule

// File: rtl/rtc_trim_wrapcnt.sv
module rtc_trim_wrapcnt #(
    parameter int MOD = 60,
    parameter int W   = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    logic [W-1:0] val_d, val_q;
    logic at_top;

    always_comb begin
        at_top = (val_q == W'(MOD - 1));
        wrap_o = step_i && at_top;
        val_d  = val_q;
        if (step_i) val_d = at_top ? '0 : (val_q + W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;
endmodule

// File: rtl/rtc_trim_timekeeper.sv
module rtc_trim_timekeeper #(
    parameter int SECS_PER_MIN  = 60,
    parameter int MINS_PER_HOUR = 60,
    parameter int HOURS_PER_DAY = 24,
    parameter int TW            = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_end_i,
    output logic [TW-1:0] sec_o,
    output logic [TW-1:0] min_o,
    output logic [TW-1:0] hour_o,
    output logic          hour_next_o,
    output logic [3:0]    pulse_o
);
    localparam int NUNITS = 3;
    localparam int MODS [NUNITS] = '{SECS_PER_MIN, MINS_PER_HOUR, HOURS_PER_DAY};

    logic [TW-1:0]     val  [NUNITS];
    logic [NUNITS:0]   step;
    logic [NUNITS-1:0] wrap;
    logic [3:0]        pulse_d, pulse_q;

    assign step[0] = sec_end_i;

    for (genvar g = 0; g < NUNITS; g++) begin : g_unit
        rtc_trim_wrapcnt #(.MOD(MODS[g]), .W(TW)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step_i(step[g]),
            .val_o (val[g]),
            .wrap_o(wrap[g])
        );
        assign step[g+1] = wrap[g];
    end

    always_comb begin
        pulse_d     = {wrap, sec_end_i};
        hour_next_o = (val[0] == TW'(SECS_PER_MIN - 1)) &&
                      (val[1] == TW'(MINS_PER_HOUR - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign sec_o   = val[0];
    assign min_o   = val[1];
    assign hour_o  = val[2];
    assign pulse_o = pulse_q;
endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
    import rtc_trim_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60,
    parameter int MINS_PER_HOUR = 60,
    parameter int HOURS_PER_DAY = 24,
    parameter int TW = $clog2((SECS_PER_MIN > MINS_PER_HOUR)
        ? ((SECS_PER_MIN > HOURS_PER_DAY) ? SECS_PER_MIN : HOURS_PER_DAY)
        : ((MINS_PER_HOUR > HOURS_PER_DAY) ? MINS_PER_HOUR : HOURS_PER_DAY))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [1:0]    addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o,
    output logic [TW-1:0] sec_o,
    output logic [TW-1:0] min_o,
    output logic [TW-1:0] hour_o,
    output logic          sec_tick_o,
    output logic          min_tick_o,
    output logic          hour_tick_o,
    output logic          day_tick_o
);
    localparam int LEN_MAX = TICKS_PER_SEC + (2 ** (COMP_W - 1));
    localparam int CW      = $clog2(LEN_MAX + 1);

    ctrl_t             ctrl;
    logic [COMP_W-1:0] trim_val;
    logic              run_w, trim_en_w;
    logic              sec_end, hour_next;
    logic [CW-1:0]     tick_cnt, sec_len;
    logic [3:0]        pulses;

    assign run_w     = ctrl.run;
    assign trim_en_w = ctrl.trim_en;

    rtc_trim_regs i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en_i(wr_en_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .ctrl_o (ctrl),
        .trim_o (trim_val)
    );

    rtc_trim_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .CW(CW)) i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (run_w),
        .trim_en_i  (trim_en_w),
        .trim_i     (trim_val),
        .hour_next_i(hour_next),
        .sec_end_o  (sec_end),
        .cnt_o      (tick_cnt),
        .len_o      (sec_len)
    );

    rtc_trim_timekeeper #(
        .SECS_PER_MIN (SECS_PER_MIN),
        .MINS_PER_HOUR(MINS_PER_HOUR),
        .HOURS_PER_DAY(HOURS_PER_DAY),
        .TW           (TW)
    ) i_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_end_i  (sec_end),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .hour_o     (hour_o),
        .hour_next_o(hour_next),
        .pulse_o    (pulses)
    );

    assign sec_tick_o  = pulses[0];
    assign min_tick_o  = pulses[1];
    assign hour_tick_o = pulses[2];
    assign day_tick_o  = pulses[3];
endmodule

// File: rtl/rtc_trim_checker.sv
module rtc_trim_checker #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60,
    parameter int MINS_PER_HOUR = 60,
    parameter int HOURS_PER_DAY = 24,
    parameter int TW            = 6,
    parameter int CW            = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          trim_en,
    input logic          wr_en,
    input logic [1:0]    addr,
    input logic [15:0]   trim_val,
    input logic [CW-1:0] tick_cnt,
    input logic [CW-1:0] sec_len,
    input logic [TW-1:0] sec_v,
    input logic [TW-1:0] min_v,
    input logic [TW-1:0] hour_v,
    input logic          sec_tick,
    input logic          min_tick,
    input logic          hour_tick,
    input logic          day_tick
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt < sec_len);

    p_len_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_len != '0);

    p_nominal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !((sec_v == '0) && (min_v == '0))) |-> (sec_len == CW'(TICKS_PER_SEC)));

    p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !$past(trim_en)) |-> (sec_len == CW'(TICKS_PER_SEC)));

    p_lo_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 2'd2)) |=> $stable(trim_val));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(tick_cnt) && $stable(sec_v) && $stable(min_v) && $stable(hour_v)));

    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_v < TW'(SECS_PER_MIN)) && (min_v < TW'(MINS_PER_HOUR)) && (hour_v < TW'(HOURS_PER_DAY)));

    p_min_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        min_tick |-> (sec_tick && (sec_v == '0)));

    p_hour_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hour_tick |-> (min_tick && (min_v == '0)));

    p_day_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        day_tick |-> (hour_tick && (hour_v == '0)));
endmodule

bind rtc_trim_core rtc_trim_checker #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SECS_PER_MIN (SECS_PER_MIN),
    .MINS_PER_HOUR(MINS_PER_HOUR),
    .HOURS_PER_DAY(HOURS_PER_DAY),
    .TW           (TW),
    .CW           (CW)
) i_rtc_trim_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .trim_en  (trim_en_w),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .trim_val (trim_val),
    .tick_cnt (tick_cnt),
    .sec_len  (sec_len),
    .sec_v    (sec_o),
    .min_v    (min_o),
    .hour_v   (hour_o),
    .sec_tick (sec_tick_o),
    .min_tick (min_tick_o),
    .hour_tick(hour_tick_o),
    .day_tick (day_tick_o)
);

// File: tb/test_rtc_trim_core.sv
module test_rtc_trim_core;
    localparam int TPS  = 16;
    localparam int SPM  = 5;
    localparam int MPH  = 3;
    localparam int HPD  = 2;
    localparam int TW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b1;
    logic          wr_en_i = 1'b0;
    logic [1:0]    addr_i = 2'd0;
    logic [7:0]    wdata_i = 8'h00;
    logic [7:0]    rdata_o;
    logic [TW-1:0] sec_o, min_o, hour_o;
    logic          sec_tick_o, min_tick_o, hour_tick_o, day_tick_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtc_trim_core #(
        .TICKS_PER_SEC(TPS),
        .SECS_PER_MIN (SPM),
        .MINS_PER_HOUR(MPH),
        .HOURS_PER_DAY(HPD),
        .TW           (TW)
    ) i_rtc_trim_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .hour_o     (hour_o),
        .sec_tick_o (sec_tick_o),
        .min_tick_o (min_tick_o),
        .hour_tick_o(hour_tick_o),
        .day_tick_o (day_tick_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_trim(input logic [15:0] v);
        bus_write(2'd1, v[7:0]);
        bus_write(2'd2, v[15:8]);
    endtask

    task automatic read_reg(input logic [1:0] a, output int d);
        addr_i = a;
        #1;
        d = int'(rdata_o);
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!sec_tick_o);
    endtask

    task automatic wait_hour_start();
        do @(negedge clk); while (!(sec_tick_o && sec_o == 0 && min_o == 0));
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sec_tick_o);
    endtask

    task automatic t_reset();
        int d;
        chk("R9 time after reset", int'({hour_o, min_o, sec_o}), 0);
        chk("R9 pulses after reset", int'({day_tick_o, hour_tick_o, min_tick_o, sec_tick_o}), 0);
        for (int a = 0; a < 3; a++) begin
            read_reg(2'(a), d);
            chk("R9 register reads zero", d, 0);
        end
    endtask

    task automatic t_commit();
        int d;
        bus_write(2'd1, 8'h34);
        read_reg(2'd1, d);
        chk("R5 low write not committed", d, 0);
        bus_write(2'd2, 8'h12);
        read_reg(2'd1, d);
        chk("R5 low byte after commit", d, 8'h34);
        read_reg(2'd2, d);
        chk("R5 high byte after commit", d, 8'h12);
    endtask

    task automatic t_nominal();
        int n;
        bus_write(2'd0, 8'h01);
        wait_pulse();
        for (int i = 0; i < 4; i++) begin
            measure(n);
            chk("R1 nominal second length", n, TPS);
        end
    endtask

    task automatic t_stop();
        int s, m, h, n, pulses;
        wait_pulse();
        bus_write(2'd0, 8'h00);
        s = sec_o; m = min_o; h = hour_o;
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sec_tick_o) pulses++;
        end
        chk("R8 no pulse while stopped", pulses, 0);
        chk("R8 time held while stopped", int'({hour_o, min_o, sec_o}), (h << 6) | (m << 3) | s);
        bus_write(2'd0, 8'h01);
        measure(n);
        chk("R8 interrupted second resumes", n, TPS - 1);
    endtask

    task automatic t_wrap();
        int es, em, eh;
        bit ws, wm, wh;
        wait_pulse();
        es = sec_o; em = min_o; eh = hour_o;
        for (int i = 0; i < 32; i++) begin
            wait_pulse();
            ws = (es == SPM - 1);
            wm = ws && (em == MPH - 1);
            wh = wm && (eh == HPD - 1);
            es = ws ? 0 : es + 1;
            if (ws) em = wm ? 0 : em + 1;
            if (wm) eh = wh ? 0 : eh + 1;
            chk("R7 time value", int'({hour_o, min_o, sec_o}), (eh << 6) | (em << 3) | es);
            chk("R7 wrap pulses", int'({day_tick_o, hour_tick_o, min_tick_o}), (int'(wh) << 2) | (int'(wm) << 1) | int'(ws));
        end
        @(negedge clk);
        chk("R7 pulse lasts one cycle", int'({day_tick_o, hour_tick_o, min_tick_o}), 0);
    endtask

    task automatic t_disabled();
        int n;
        set_trim(16'd3);
        wait_hour_start();
        measure(n);
        chk("R4 trim ignored with enable clear", n, TPS);
    endtask

    task automatic t_positive();
        int n;
        bus_write(2'd0, 8'h03);
        wait_hour_start();
        measure(n);
        chk("R2 positive trim shortens first second", n, TPS - 3);
        measure(n);
        chk("R1 second after trimmed one is nominal", n, TPS);
    endtask

    task automatic t_sample();
        int n;
        wait_hour_start();
        set_trim(16'hFFFC);
        n = 2;
        do begin @(negedge clk); n++; end while (!sec_tick_o);
        chk("R6 mid-second commit leaves current second", n, TPS - 3);
        wait_hour_start();
        measure(n);
        chk("R6 new trim applies at next hour", n, TPS + 4);
    endtask

    task automatic t_negative();
        int n;
        set_trim(16'hFFF0);
        wait_hour_start();
        measure(n);
        chk("R3 negative trim lengthens second", n, TPS + 16);
        set_trim(16'h8000);
        wait_hour_start();
        measure(n);
        chk("R3 most negative trim", n, TPS + 32768);
    endtask

    task automatic t_floor();
        int n;
        set_trim(16'd20);
        wait_hour_start();
        measure(n);
        chk("R10 oversize trim gives one tick", n, 1);
        measure(n);
        chk("R10 following second nominal", n, TPS);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit();
        t_nominal();
        t_stop();
        t_wrap();
        t_disabled();
        t_positive();
        t_sample();
        t_negative();
        t_floor();
        finish_up();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end
endmodule